// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit with Selective Overflow

This block is the purely combinational execute unit of a load-store RISC integer pipeline. Each cycle it receives two register operands, a 4-bit function code, a 16-bit immediate with a flag that swaps it in for the second operand, a 5-bit constant shift amount and a flag that takes the shift amount from a register instead. It returns a 32-bit result and an overflow flag that the surrounding core turns into an exception.

The unit covers wrapping and trapping addition and subtraction, the four bitwise operations, signed and unsigned less-than compares, three shifts and the load of an immediate into the upper half-word. Only the trapping add and subtract raise the overflow flag. The immediate is extended according to the class of the operation: arithmetic and compare operations sign-extend it, even their unsigned forms, while bitwise operations zero-extend it. A shift always moves the second register operand and never uses the immediate. The function code alone selects the operation and the extension, so the decoder does not need a separate extension control.

There are no clocks, no registers and no state. A result settles within the cycle its inputs are applied.

Top module: `int_alu`

## Requirements
- R1: Function code 0 (add), 1 (wrapping add), 2 (subtract) and 3 (wrapping subtract) return the sum or difference of the two operands modulo 2^32.
- R2: Codes 0 and 2 raise `ovf` on two's-complement overflow, including when `use_imm` is 1. An add overflows when the operands have the same sign and the result has the other sign. A subtract overflows when the operands have different signs and the result sign differs from `op_a`.
- R3: Codes 1 and 3, the bitwise operations, the compares, the shifts, the upper load and the unassigned codes 14 and 15 never raise `ovf`.
- R4: With `use_imm` = 1, codes 0 to 3, 8 (signed less-than) and 9 (unsigned less-than) use `imm` sign-extended to 32 bits in place of `op_b`.
- R5: With `use_imm` = 1, codes 4 (AND), 5 (OR) and 6 (XOR) use `imm` zero-extended to 32 bits in place of `op_b`.
- R6: Codes 4, 5 and 6 return the bitwise AND, OR and XOR of the operands, and code 7 returns the bitwise inverse of their OR.
- R7: Code 8 returns 1 in bit 0, with all other bits 0, when `op_a` is below the second operand in two's-complement order, and 0 otherwise. This holds even when the internal difference overflows.
- R8: Code 9 compares in natural-number order. All-ones against 1 gives 0 here, whereas code 8 gives 1 for the same pair.
- R9: Code 13 returns `imm` in bits 31:16 and zero in bits 15:0.
- R10: Codes 10 (left), 11 (logical right) and 12 (arithmetic right) shift `op_b`. The left shift and the logical right shift fill vacated bits with zero. The arithmetic right shift fills them with bit 31 of `op_b`.
- R11: With `shift_var` = 0 the shift amount is `shamt`. With `shift_var` = 1 it is bits 4:0 of `op_a`, and the upper bits of `op_a` and the value of `shamt` have no effect.
- R12: Unassigned codes 14 and 15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| func | input | 4 | Operation code (0 to 13 assigned) |
| op_a | input | 32 | First register operand; low 5 bits give the variable shift amount |
| op_b | input | 32 | Second register operand; the value moved by the shifts |
| imm | input | 16 | Immediate field |
| use_imm | input | 1 | Replace the second operand with the extended immediate |
| shamt | input | 5 | Constant shift amount |
| shift_var | input | 1 | Take the shift amount from `op_a` instead of `shamt` |
| result | output | 32 | Operation result |
| ovf | output | 1 | Overflow exception request |

## Verification
The signed compare and an overflowing subtraction happen in the same cycle, because the compare is decided from the difference. The bench provokes this with pairs such as 0x80000000 against 1 and 0x7FFFFFFF against 0xFFFFFFFF. It judges the case by requiring the true signed order in bit 0 with `ovf` held low. Sign extension and overflow also meet in add-immediate. A vector whose sign-extended immediate pushes a positive operand past the top of the range must show both the wrapped result and a raised flag.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        FN_ADD   = 4'd0,
        FN_ADDW  = 4'd1,
        FN_SUB   = 4'd2,
        FN_SUBW  = 4'd3,
        FN_AND   = 4'd4,
        FN_OR    = 4'd5,
        FN_XOR   = 4'd6,
        FN_NOR   = 4'd7,
        FN_LTS   = 4'd8,
        FN_LTU   = 4'd9,
        FN_SHL   = 4'd10,
        FN_SHRL  = 4'd11,
        FN_SHRA  = 4'd12,
        FN_UPPER = 4'd13
    } alu_fn_e;

    function automatic logic fn_is_bitwise(input alu_fn_e f);
        return (f == FN_AND) || (f == FN_OR) || (f == FN_XOR) || (f == FN_NOR);
    endfunction

    function automatic logic fn_is_subtract(input alu_fn_e f);
        return (f == FN_SUB) || (f == FN_SUBW) || (f == FN_LTS) || (f == FN_LTU);
    endfunction

endpackage

// File: rtl/alu_operand.sv
module alu_operand #(
    parameter int W     = 32,
    parameter int IMM_W = 16
) (
    input  logic [W-1:0]     reg_b,
    input  logic [IMM_W-1:0] imm,
    input  logic             use_imm,
    input  logic             zero_ext,
    output logic [W-1:0]     b_eff
);
    localparam int UPPER = W - IMM_W;

    logic [W-1:0] imm_ext;

    always_comb begin
        if (zero_ext) imm_ext = {{UPPER{1'b0}}, imm};
        else          imm_ext = {{UPPER{imm[IMM_W-1]}}, imm};
        b_eff = use_imm ? imm_ext : reg_b;
    end

    always_comb begin
        if (use_imm && zero_ext)
            AST_ZERO_EXT_UPPER: assert (b_eff[W-1:IMM_W] == '0); // R5
        if (use_imm && !zero_ext)
            AST_SIGN_EXT_UPPER: assert (b_eff[W-1] == imm[IMM_W-1]); // R4
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         ovf_raw
);
    logic [W-1:0] b_adj;
    logic [W:0]   wide;

    always_comb begin
        b_adj   = b ^ {W{sub}};
        wide    = {1'b0, a} + {1'b0, b_adj} + {{W{1'b0}}, sub};
        sum     = wide[W-1:0];
        carry   = wide[W];
        ovf_raw = (a[W-1] == b_adj[W-1]) && (sum[W-1] != a[W-1]);
    end

    always_comb begin
        if (!sub && (a[W-1] != b[W-1]))
            AST_MIXED_SIGN_ADD: assert (!ovf_raw); // R2
        if (sub && (a[W-1] == b[W-1]))
            AST_SAME_SIGN_SUB: assert (!ovf_raw); // R2
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int W = 32
) (
    input  logic [W-1:0]         value,
    input  logic [$clog2(W)-1:0] amt,
    input  logic                 right,
    input  logic                 arith,
    output logic [W-1:0]         shifted
);
    localparam int STAGES = $clog2(W);

    logic          fill;
    logic [W-1:0]  lft [STAGES+1];
    logic [W-1:0]  rgt [STAGES+1];

    assign fill   = arith & value[W-1];
    assign lft[0] = value;
    assign rgt[0] = value;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        localparam int D = 1 << s;
        assign lft[s+1] = amt[s] ? {lft[s][W-1-D:0], {D{1'b0}}} : lft[s];
        assign rgt[s+1] = amt[s] ? {{D{fill}}, rgt[s][W-1:D]}  : rgt[s];
    end

    assign shifted = right ? rgt[STAGES] : lft[STAGES];

    always_comb begin
        if (right && arith && value[W-1])
            AST_SRA_SIGN_FILL: assert (shifted[W-1]); // R10
        if (right && !arith && (amt != '0))
            AST_SRL_ZERO_TOP: assert (!shifted[W-1]); // R10
    end
endmodule

// File: rtl/int_alu.sv
module int_alu #(
    parameter int W     = 32,
    parameter int IMM_W = 16
) (
    input  logic [3:0]           func,
    input  logic [W-1:0]         op_a,
    input  logic [W-1:0]         op_b,
    input  logic [IMM_W-1:0]     imm,
    input  logic                 use_imm,
    input  logic [$clog2(W)-1:0] shamt,
    input  logic                 shift_var,
    output logic [W-1:0]         result,
    output logic                 ovf
);
    import alu_pkg::*;

    localparam int SH_W = $clog2(W);

    alu_fn_e        fn;
    logic [W-1:0]   b_eff;
    logic [W-1:0]   sum;
    logic           carry;
    logic           ovf_raw;
    logic [SH_W-1:0] amt;
    logic [W-1:0]   shifted;
    logic           less_s;
    logic           less_u;

    assign fn  = alu_fn_e'(func);
    assign amt = shift_var ? op_a[SH_W-1:0] : shamt;

    alu_operand #(.W(W), .IMM_W(IMM_W)) u_operand (
        .reg_b    (op_b),
        .imm      (imm),
        .use_imm  (use_imm),
        .zero_ext (fn_is_bitwise(fn)),
        .b_eff    (b_eff)
    );

    alu_addsub #(.W(W)) u_addsub (
        .a       (op_a),
        .b       (b_eff),
        .sub     (fn_is_subtract(fn)),
        .sum     (sum),
        .carry   (carry),
        .ovf_raw (ovf_raw)
    );

    alu_shift #(.W(W)) u_shift (
        .value   (op_b),
        .amt     (amt),
        .right   ((fn == FN_SHRL) || (fn == FN_SHRA)),
        .arith   (fn == FN_SHRA),
        .shifted (shifted)
    );

    assign less_s = sum[W-1] ^ ovf_raw;
    assign less_u = ~carry;

    always_comb begin
        result = '0;
        ovf    = 1'b0;
        unique case (fn)
            FN_ADD:   begin result = sum; ovf = ovf_raw; end
            FN_SUB:   begin result = sum; ovf = ovf_raw; end
            FN_ADDW,
            FN_SUBW:  result = sum;
            FN_AND:   result = op_a & b_eff;
            FN_OR:    result = op_a | b_eff;
            FN_XOR:   result = op_a ^ b_eff;
            FN_NOR:   result = ~(op_a | b_eff);
            FN_LTS:   result = {{(W-1){1'b0}}, less_s};
            FN_LTU:   result = {{(W-1){1'b0}}, less_u};
            FN_SHL,
            FN_SHRL,
            FN_SHRA:  result = shifted;
            FN_UPPER: result = {imm, {(W-IMM_W){1'b0}}};
            default:  result = '0;
        endcase
    end

    always_comb begin
        if ((fn != FN_ADD) && (fn != FN_SUB))
            AST_NO_OVERFLOW: assert (!ovf); // R3
        if (fn == FN_UPPER)
            AST_UPPER_LOW_CLEAR: assert (result[W-IMM_W-1:0] == '0); // R9
        if ((fn == FN_LTS) || (fn == FN_LTU))
            AST_COMPARE_BOOL: assert (result[W-1:1] == '0); // R7
        if ((fn == FN_LTS) && (op_a[W-1] != b_eff[W-1]))
            AST_LTS_SIGN_DECIDES: assert (result[0] == op_a[W-1]); // R7
        if (func > 4'd13)
            AST_UNUSED_ZERO: assert (result == '0); // R12
    end
endmodule

// File: tb/int_alu_test.sv
module int_alu_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;
    localparam int NV         = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [3:0]  func;
    logic [31:0] op_a, op_b;
    logic [15:0] imm;
    logic        use_imm, shift_var;
    logic [4:0]  shamt;
    logic [31:0] result;
    logic        ovf;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int_alu uut (
        .func(func), .op_a(op_a), .op_b(op_b), .imm(imm),
        .use_imm(use_imm), .shamt(shamt), .shift_var(shift_var),
        .result(result), .ovf(ovf)
    );

    // {func, use_imm, shift_var, shamt, imm, a, b, expected result, expected ovf}
    localparam logic [123:0] VEC [NV] = '{
        {4'd0, 1'b0,1'b0,5'd0, 16'h0000, 32'h00000007, 32'h00000005, 32'h0000000C, 1'b0}, // R1
        {4'd0, 1'b0,1'b0,5'd0, 16'h0000, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b1}, // R2
        {4'd0, 1'b0,1'b0,5'd0, 16'h0000, 32'h80000000, 32'h80000000, 32'h00000000, 1'b1}, // R2
        {4'd1, 1'b0,1'b0,5'd0, 16'h0000, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0}, // R3
        {4'd2, 1'b0,1'b0,5'd0, 16'h0000, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b1}, // R2
        {4'd2, 1'b0,1'b0,5'd0, 16'h0000, 32'h00000005, 32'h00000007, 32'hFFFFFFFE, 1'b0}, // R1
        {4'd3, 1'b0,1'b0,5'd0, 16'h0000, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b0}, // R3
        {4'd0, 1'b1,1'b0,5'd0, 16'h0010, 32'h7FFFFFF0, 32'h00000000, 32'h80000000, 1'b1}, // R2 R4
        {4'd1, 1'b1,1'b0,5'd0, 16'hFFFF, 32'h00000010, 32'h12345678, 32'h0000000F, 1'b0}, // R4
        {4'd9, 1'b1,1'b0,5'd0, 16'hFFFF, 32'h00000005, 32'h00000000, 32'h00000001, 1'b0}, // R4
        {4'd4, 1'b1,1'b0,5'd0, 16'h8001, 32'hFFFFFFFF, 32'h00000000, 32'h00008001, 1'b0}, // R5
        {4'd5, 1'b1,1'b0,5'd0, 16'hFFFF, 32'h00000000, 32'hFFFFFFFF, 32'h0000FFFF, 1'b0}, // R5
        {4'd6, 1'b1,1'b0,5'd0, 16'hFFFF, 32'hF0F0F0F0, 32'h00000000, 32'hF0F00F0F, 1'b0}, // R5
        {4'd4, 1'b0,1'b0,5'd0, 16'h0000, 32'hFF00FF00, 32'h0F0F0F0F, 32'h0F000F00, 1'b0}, // R6
        {4'd7, 1'b0,1'b0,5'd0, 16'h0000, 32'hF0F00000, 32'h0000000F, 32'h0F0FFFF0, 1'b0}, // R6
        {4'd8, 1'b0,1'b0,5'd0, 16'h0000, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 1'b0}, // R7
        {4'd8, 1'b0,1'b0,5'd0, 16'h0000, 32'h80000000, 32'h00000001, 32'h00000001, 1'b0}, // R7
        {4'd8, 1'b0,1'b0,5'd0, 16'h0000, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b0}, // R7
        {4'd9, 1'b0,1'b0,5'd0, 16'h0000, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b0}, // R8
        {4'd9, 1'b0,1'b0,5'd0, 16'h0000, 32'h00000001, 32'hFFFFFFFF, 32'h00000001, 1'b0}, // R8
        {4'd13,1'b0,1'b0,5'd0, 16'hABCD, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hABCD0000, 1'b0}, // R9
        {4'd10,1'b0,1'b0,5'd4, 16'h0000, 32'h00000000, 32'h8000000F, 32'h000000F0, 1'b0}, // R10
        {4'd11,1'b0,1'b0,5'd4, 16'h0000, 32'h00000000, 32'h80000000, 32'h08000000, 1'b0}, // R10
        {4'd12,1'b0,1'b0,5'd4, 16'h0000, 32'h00000000, 32'h80000000, 32'hF8000000, 1'b0}, // R10
        {4'd12,1'b0,1'b0,5'd31,16'h0000, 32'h00000000, 32'h80000000, 32'hFFFFFFFF, 1'b0}, // R10
        {4'd12,1'b0,1'b0,5'd4, 16'h0000, 32'h00000000, 32'h70000000, 32'h07000000, 1'b0}, // R10
        {4'd10,1'b0,1'b1,5'd31,16'h0000, 32'hFFFFFFE3, 32'h00000001, 32'h00000008, 1'b0}, // R11
        {4'd11,1'b0,1'b1,5'd7, 16'h0000, 32'h00000020, 32'hDEADBEEF, 32'hDEADBEEF, 1'b0}, // R11
        {4'd12,1'b0,1'b1,5'd0, 16'h0000, 32'h00000024, 32'h80000000, 32'hF8000000, 1'b0}, // R11
        {4'd10,1'b0,1'b0,5'd0, 16'h0000, 32'h00000000, 32'h12345678, 32'h12345678, 1'b0}, // R10
        {4'd0, 1'b1,1'b0,5'd0, 16'h8000, 32'h00000000, 32'h00000001, 32'hFFFF8000, 1'b0}, // R4
        {4'd3, 1'b0,1'b0,5'd0, 16'h0000, 32'h00000000, 32'h00000001, 32'hFFFFFFFF, 1'b0}  // R1
    };

    task automatic apply(input logic [3:0] f, input logic ui, input logic sv,
                         input logic [4:0] sa, input logic [15:0] im,
                         input logic [31:0] a, input logic [31:0] b);
        @(posedge clk);
        func = f; use_imm = ui; shift_var = sv; shamt = sa; imm = im; op_a = a; op_b = b;
        @(negedge clk);
    endtask

    task automatic judge(input string req, input logic [31:0] exp_r, input logic exp_o);
        checks++;
        if (result !== exp_r || ovf !== exp_o) begin
            errors++;
            $display("FAIL %s func=%0d result=%h ovf=%b expected result=%h ovf=%b",
                     req, func, result, ovf, exp_r, exp_o);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        func = 4'd0; use_imm = 1'b0; shift_var = 1'b0; shamt = 5'd0;
        imm = 16'h0; op_a = 32'h0; op_b = 32'h0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        judge("R1 idle zero inputs", 32'h0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][123:120], VEC[i][119], VEC[i][118], VEC[i][117:113],
                  VEC[i][112:97], VEC[i][96:65], VEC[i][64:33]);
            judge($sformatf("vector %0d R1-group", i), VEC[i][32:1], VEC[i][0]);
        end

        // R12: unassigned codes return zero and never flag
        apply(4'd14, 1'b0, 1'b0, 5'd3, 16'hFFFF, 32'h7FFFFFFF, 32'h00000001);
        judge("R12 code 14", 32'h0, 1'b0);
        apply(4'd15, 1'b1, 1'b1, 5'd3, 16'hFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF);
        judge("R12 R3 code 15", 32'h0, 1'b0);
        // R6: XOR and OR on register operands
        apply(4'd6, 1'b0, 1'b0, 5'd0, 16'h0, 32'hAAAA5555, 32'hFFFF0000);
        judge("R6 xor", 32'h5555_5555, 1'b0);
        apply(4'd5, 1'b0, 1'b0, 5'd0, 16'h0, 32'h00F0000F, 32'h0F000F00);
        judge("R6 or", 32'h0FF00F0F, 1'b0);
        // R11: constant amount ignores op_a
        apply(4'd11, 1'b0, 1'b0, 5'd8, 16'h0, 32'h0000001F, 32'hFF000000);
        judge("R11 constant amount", 32'h00FF0000, 1'b0);
        // R2: subtract-immediate style via code 2 with sign-extended immediate
        apply(4'd2, 1'b1, 1'b0, 5'd0, 16'h0001, 32'h80000000, 32'h0);
        judge("R2 R4 subtract imm overflow", 32'h7FFFFFFF, 1'b1);
        // R8 vs R7 same pair
        apply(4'd8, 1'b1, 1'b0, 5'd0, 16'h0001, 32'hFFFFFFFF, 32'h0);
        judge("R7 signed all-ones vs 1 imm", 32'h1, 1'b0);
        apply(4'd9, 1'b1, 1'b0, 5'd0, 16'h0001, 32'hFFFFFFFF, 32'h0);
        judge("R8 unsigned all-ones vs 1 imm", 32'h0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule